// File: doc/BRIEF.md
# Packet-Filtered Audio Clock-Crossing Buffer

This block sits between a network receive path and an audio playback path that run on unrelated clocks. On the network side, 32-bit words arrive with a per-cycle valid strobe. They are written into a dual-clock buffer as a tentative packet. Each packet ends with one of two single-cycle verdict strobes: the CRC checked good, or the CRC checked bad. A good verdict on a packet of exactly the configured length makes the whole packet visible to the audio side. Any other ending rewinds the tentative write position, so no word of a rejected packet is ever played.

The audio side asks for one word at a time with a request line. When a committed word is available, the block returns it one cycle later with a valid flag. The committed position crosses into the audio domain as a Gray-coded pointer through a two-flop synchroniser. The read position crosses back the same way so that the write side can detect a full buffer. Each domain has its own synchronous active-high reset, and the two resets are released together. The packet length and the buffer depth are parameters.

Top module: `pfab_top`

## Requirements
- R1: A word on `net_data` is taken only in a cycle where `net_valid` is high. Words taken into a committed packet are delivered on `aud_data` in the order they arrived, and values present while `net_valid` is low never appear.
- R2: A packet of exactly `PKT_WORDS` taken words that ends with `net_eop_good` high (and `net_eop_bad` low) is committed in full and delivered.
- R3: A packet that ends with `net_eop_bad` is discarded: none of its words is delivered, and a later good packet is delivered normally.
- R4: A packet with fewer or more than `PKT_WORDS` taken words is discarded even when it ends with `net_eop_good`.
- R5: When `net_eop_good` and `net_eop_bad` are high in the same cycle, the packet is treated as bad and discarded.
- R6: If the buffer has no free entry when a word of a packet arrives, that packet is discarded, committed words already stored stay intact and are delivered, and later packets are accepted again once space is freed.
- R7: `aud_valid` is high only in the cycle after a cycle where `aud_req` was high and a committed word was available. A request made while the buffer is empty gives no valid, and holding the request yields valid once data has been committed.
- R8: The committed write position moves into the audio domain in Gray code, changing at most one bit per network clock. Committed words therefore reach the audio side within a bounded time after the verdict.
- R9: After reset, `aud_valid` is low and the buffer holds no words.
- R10: A word presented with `net_valid` in the same cycle as the verdict strobe belongs to the packet that is ending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| net_clk | input | 1 | Network-side clock (25 MHz class) |
| net_rst | input | 1 | Synchronous active-high reset, network domain |
| net_data | input | DATA_W | Incoming packet word |
| net_valid | input | 1 | `net_data` carries a word this cycle |
| net_eop_good | input | 1 | One-cycle end-of-packet strobe, CRC correct |
| net_eop_bad | input | 1 | One-cycle end-of-packet strobe, CRC wrong |
| aud_clk | input | 1 | Audio-side clock (12.288 MHz class) |
| aud_rst | input | 1 | Synchronous active-high reset, audio domain |
| aud_req | input | 1 | Request for the next audio word |
| aud_data | output | DATA_W | Delivered audio word |
| aud_valid | output | 1 | `aud_data` holds a delivered word this cycle |

## Verification
The assertions assume that both resets start high at time zero and are released together. They also assume that a verdict strobe lasts one cycle and that the strobes never arrive faster than one per packet. The window and rollback checks rely on these points. The stimulus drives every input at the falling edge of its own clock, raises each strobe for exactly one cycle, and leaves at least one idle cycle between packets. It fills the buffer to the limit only while the audio request is held low and the pointers have settled, so that the exact capacity is known when the overflow case runs.

// File: rtl/pfab_pkg.sv
package pfab_pkg;
  localparam int GRAY_MAX_W = 16;

  function automatic logic [GRAY_MAX_W-1:0] to_gray(input logic [GRAY_MAX_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GRAY_MAX_W-1:0] from_gray(input logic [GRAY_MAX_W-1:0] g);
    logic [GRAY_MAX_W-1:0] b;
    b[GRAY_MAX_W-1] = g[GRAY_MAX_W-1];
    for (int i = GRAY_MAX_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction
endpackage

// File: rtl/pfab_sync.sv
module pfab_sync #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pfab_mem.sv
module pfab_mem #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rclk,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/pfab_wr_ctrl.sv
module pfab_wr_ctrl #(
  parameter int ADDR_W    = 5,
  parameter int PKT_WORDS = 8,
  localparam int PTR_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              eop_good,
  input  logic              eop_bad,
  input  logic [PTR_W-1:0]  rptr_gray_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTR_W-1:0]  pub_gray,
  output logic [PTR_W-1:0]  tent_ptr,
  output logic [PTR_W-1:0]  cmt_ptr,
  output logic [PTR_W-1:0]  rptr_bin_s
);
  import pfab_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(PKT_WORDS + 1);

  logic [CNT_W-1:0] cnt, cnt_n;
  logic             drop, drop_n;
  logic             full, at_len, acc, keep;
  logic [PTR_W-1:0] tent_n, pub, pub_n;

  assign rptr_bin_s = PTR_W'(from_gray(GRAY_MAX_W'(rptr_gray_s)));
  assign full       = (tent_ptr - rptr_bin_s) == PTR_W'(DEPTH);
  assign at_len     = cnt == CNT_W'(PKT_WORDS);
  assign acc        = in_valid && !drop && !at_len && !full;
  assign drop_n     = drop || (in_valid && (at_len || full));
  assign cnt_n      = cnt + CNT_W'(acc);
  assign tent_n     = tent_ptr + PTR_W'(acc);
  assign keep       = eop_good && !eop_bad && !drop_n && (cnt_n == CNT_W'(PKT_WORDS));
  assign pub_n      = (pub != cmt_ptr) ? pub + PTR_W'(1) : pub;

  assign wr_en   = acc;
  assign wr_addr = tent_ptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      drop     <= 1'b0;
      tent_ptr <= '0;
      cmt_ptr  <= '0;
      pub      <= '0;
      pub_gray <= '0;
    end else begin
      if (eop_good || eop_bad) begin
        cnt  <= '0;
        drop <= 1'b0;
        if (keep) begin
          cmt_ptr  <= tent_n;
          tent_ptr <= tent_n;
        end else begin
          tent_ptr <= cmt_ptr;
        end
      end else begin
        cnt      <= cnt_n;
        drop     <= drop_n;
        tent_ptr <= tent_n;
      end
      pub      <= pub_n;
      pub_gray <= PTR_W'(to_gray(GRAY_MAX_W'(pub_n)));
    end
  end
endmodule

// File: rtl/pfab_rd_ctrl.sv
module pfab_rd_ctrl #(
  parameter int ADDR_W = 5,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [PTR_W-1:0]  wptr_gray_s,
  output logic              take,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [PTR_W-1:0]  rptr_gray,
  output logic              out_valid
);
  import pfab_pkg::*;

  logic [PTR_W-1:0] rptr, rptr_n, wptr_s;
  logic             empty;

  assign wptr_s  = PTR_W'(from_gray(GRAY_MAX_W'(wptr_gray_s)));
  assign empty   = rptr == wptr_s;
  assign take    = req && !empty;
  assign rptr_n  = rptr + PTR_W'(take);
  assign rd_addr = rptr[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr      <= '0;
      rptr_gray <= '0;
      out_valid <= 1'b0;
    end else begin
      rptr      <= rptr_n;
      rptr_gray <= PTR_W'(to_gray(GRAY_MAX_W'(rptr_n)));
      out_valid <= take;
    end
  end
endmodule

// File: rtl/pfab_top.sv
module pfab_top #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 5,
  parameter int PKT_WORDS = 8
) (
  input  logic              net_clk,
  input  logic              net_rst,
  input  logic [DATA_W-1:0] net_data,
  input  logic              net_valid,
  input  logic              net_eop_good,
  input  logic              net_eop_bad,
  input  logic              aud_clk,
  input  logic              aud_rst,
  input  logic              aud_req,
  output logic [DATA_W-1:0] aud_data,
  output logic              aud_valid
);
  localparam int PTR_W = ADDR_W + 1;

  logic              wr_en, rd_take;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [PTR_W-1:0]  pub_gray, pub_gray_s, rptr_gray, rptr_gray_s;
  logic [PTR_W-1:0]  tent_ptr, cmt_ptr, rptr_bin_s;

  pfab_wr_ctrl #(.ADDR_W(ADDR_W), .PKT_WORDS(PKT_WORDS)) u_wr (
    .clk(net_clk), .rst(net_rst), .in_valid(net_valid),
    .eop_good(net_eop_good), .eop_bad(net_eop_bad),
    .rptr_gray_s(rptr_gray_s), .wr_en(wr_en), .wr_addr(wr_addr),
    .pub_gray(pub_gray), .tent_ptr(tent_ptr), .cmt_ptr(cmt_ptr),
    .rptr_bin_s(rptr_bin_s)
  );

  pfab_sync #(.W(PTR_W)) u_sync_w2r (
    .clk(aud_clk), .rst(aud_rst), .d(pub_gray), .q(pub_gray_s)
  );

  pfab_sync #(.W(PTR_W)) u_sync_r2w (
    .clk(net_clk), .rst(net_rst), .d(rptr_gray), .q(rptr_gray_s)
  );

  pfab_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
    .clk(aud_clk), .rst(aud_rst), .req(aud_req), .wptr_gray_s(pub_gray_s),
    .take(rd_take), .rd_addr(rd_addr), .rptr_gray(rptr_gray),
    .out_valid(aud_valid)
  );

  pfab_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(net_clk), .we(wr_en), .waddr(wr_addr), .wdata(net_data),
    .rclk(aud_clk), .re(rd_take), .raddr(rd_addr), .rdata(aud_data)
  );
endmodule

// File: rtl/pfab_top_chk.sv
module pfab_top_chk #(
  parameter int ADDR_W    = 5,
  parameter int PKT_WORDS = 8,
  localparam int PTR_W    = ADDR_W + 1
) (
  input logic             net_clk,
  input logic             net_rst,
  input logic             net_eop_bad,
  input logic             aud_clk,
  input logic             aud_rst,
  input logic             aud_req,
  input logic             aud_valid,
  input logic [PTR_W-1:0] tent_ptr,
  input logic [PTR_W-1:0] cmt_ptr,
  input logic [PTR_W-1:0] pub_gray,
  input logic [PTR_W-1:0] rptr_bin_s
);
  localparam int DEPTH = 1 << ADDR_W;

  AST_TENT_WINDOW: assert property (@(posedge net_clk) disable iff (net_rst)
    PTR_W'(tent_ptr - cmt_ptr) <= PTR_W'(PKT_WORDS)); // R2

  AST_COMMIT_WHOLE: assert property (@(posedge net_clk) disable iff (net_rst)
    (cmt_ptr != $past(cmt_ptr)) |-> (PTR_W'(cmt_ptr - $past(cmt_ptr)) == PTR_W'(PKT_WORDS))); // R4

  AST_ROLLBACK: assert property (@(posedge net_clk) disable iff (net_rst)
    net_eop_bad |=> (tent_ptr == $past(cmt_ptr))); // R3

  AST_GRAY_STEP: assert property (@(posedge net_clk) disable iff (net_rst)
    $countones(pub_gray ^ $past(pub_gray)) <= 1); // R8

  AST_NO_OVERFLOW: assert property (@(posedge net_clk) disable iff (net_rst)
    PTR_W'(tent_ptr - rptr_bin_s) <= PTR_W'(DEPTH)); // R6

  AST_VALID_AFTER_REQ: assert property (@(posedge aud_clk) disable iff (aud_rst)
    aud_valid |-> $past(aud_req)); // R7

  AST_RESET_QUIET: assert property (@(posedge aud_clk) disable iff (aud_rst)
    $past(aud_rst) |-> !aud_valid); // R9
endmodule

bind pfab_top pfab_top_chk #(.ADDR_W(ADDR_W), .PKT_WORDS(PKT_WORDS)) u_chk (
  .net_clk(net_clk), .net_rst(net_rst), .net_eop_bad(net_eop_bad),
  .aud_clk(aud_clk), .aud_rst(aud_rst), .aud_req(aud_req),
  .aud_valid(aud_valid), .tent_ptr(tent_ptr), .cmt_ptr(cmt_ptr),
  .pub_gray(pub_gray), .rptr_bin_s(rptr_bin_s)
);

// File: tb/pfab_top_test.sv
module pfab_top_test;
  localparam int DW    = 32;
  localparam int AW    = 5;
  localparam int PKT   = 8;
  localparam int DEPTH = 1 << AW;

  logic          net_clk = 1'b0, aud_clk = 1'b0;
  logic          net_rst = 1'b1, aud_rst = 1'b1;
  logic [DW-1:0] net_data = '0;
  logic          net_valid = 1'b0, net_eop_good = 1'b0, net_eop_bad = 1'b0;
  logic          aud_req = 1'b0;
  logic [DW-1:0] aud_data;
  logic          aud_valid;

  always #2 net_clk = ~net_clk;
  initial begin
    #1;
    forever #5 aud_clk = ~aud_clk;
  end

  pfab_top #(.DATA_W(DW), .ADDR_W(AW), .PKT_WORDS(PKT)) uut (.*);

  int vectors = 0, errors = 0;
  int delivered = 0, expected_total = 0;
  int word_seq = 0;
  bit rd_en = 1'b0;
  logic [DW-1:0] exp_q[$];

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Audio-side monitor and request driver, both at the falling edge.
  always @(negedge aud_clk) begin
    if (!aud_rst) begin
      if (aud_valid) begin
        vectors++;
        if (!aud_req) begin
          errors++;
          $display("FAIL R7 valid without request actual=1 expected=0");
        end
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected word actual=%h expected=none", aud_data);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          if (aud_data !== e) begin
            errors++;
            $display("FAIL R1 word order actual=%h expected=%h", aud_data, e);
          end
          delivered++;
        end
      end
    end
    aud_req = rd_en;
  end

  // Sends n words; the verdict follows the last word or shares its cycle.
  task automatic send_pkt(input int n, input bit good, input bit bad,
                          input bit gaps, input bit eop_with_last);
    logic [DW-1:0] pkt[$];
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        @(negedge net_clk);
        net_valid = 1'b0;
        net_data  = 32'hBAD0_0000 | DW'(i);
      end
      @(negedge net_clk);
      word_seq++;
      net_valid = 1'b1;
      net_data  = 32'hA500_0000 | DW'(word_seq);
      pkt.push_back(net_data);
      if (eop_with_last && i == n - 1) begin
        net_eop_good = good;
        net_eop_bad  = bad;
      end
    end
    @(negedge net_clk);
    net_valid = 1'b0;
    net_data  = 32'hBAD1_0000;
    if (!eop_with_last || n == 0) begin
      net_eop_good = good;
      net_eop_bad  = bad;
      @(negedge net_clk);
    end
    net_eop_good = 1'b0;
    net_eop_bad  = 1'b0;
    @(negedge net_clk);
    if (good && !bad && pkt.size() == PKT && exp_q.size() + PKT <= DEPTH) begin
      foreach (pkt[k]) exp_q.push_back(pkt[k]);
      expected_total += PKT;
    end
  endtask

  task automatic drain_check(input string req);
    rd_en = 1'b1;
    repeat (150) @(negedge aud_clk);
    chk(req, delivered == expected_total, delivered, expected_total);
    chk(req, exp_q.size() == 0, exp_q.size(), 0);
  endtask

  initial begin
    fork
      begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    join_none

    repeat (6) @(negedge net_clk);
    net_rst = 1'b0;
    aud_rst = 1'b0;
    @(negedge aud_clk);
    chk("R9 reset valid", aud_valid == 1'b0, aud_valid, 0);

    // R7 and R9: requests against an empty buffer produce nothing.
    rd_en = 1'b1;
    repeat (30) @(negedge aud_clk);
    chk("R7 empty request", delivered == 0, delivered, 0);

    // R2 and R7: a plain good packet arrives while the request is held.
    send_pkt(PKT, 1, 0, 0, 0);
    drain_check("R2 good packet");

    // R1: idle cycles carry junk data that must not be taken.
    send_pkt(PKT, 1, 0, 1, 0);
    drain_check("R1 gapped packet");

    // R3: a bad packet vanishes, then a good one passes.
    send_pkt(PKT, 0, 1, 0, 0);
    drain_check("R3 bad packet");
    send_pkt(PKT, 1, 0, 1, 0);
    drain_check("R3 after bad");

    // R4: short and long packets with a good verdict.
    send_pkt(PKT - 1, 1, 0, 0, 0);
    drain_check("R4 short packet");
    send_pkt(PKT + 1, 1, 0, 0, 0);
    drain_check("R4 long packet");

    // R5: both verdicts at once.
    send_pkt(PKT, 1, 1, 0, 0);
    drain_check("R5 both strobes");

    // R10: last word shares the verdict cycle.
    send_pkt(PKT, 1, 0, 0, 1);
    drain_check("R10 word with strobe");
    send_pkt(PKT - 1, 1, 0, 0, 1);
    drain_check("R10 short with strobe");

    // R8: committed words reach the reader within a bounded time.
    send_pkt(PKT, 1, 0, 0, 0);
    repeat (PKT + 2 * PKT + 10) @(negedge aud_clk);
    chk("R8 crossing latency", delivered == expected_total, delivered, expected_total);
    drain_check("R8 drain");

    // R6: fill with the reader stopped, then one packet too many.
    rd_en = 1'b0;
    repeat (20) @(negedge aud_clk);
    for (int p = 0; p < DEPTH / PKT + 1; p++) send_pkt(PKT, 1, 0, 0, 0);
    repeat (60) @(negedge aud_clk);
    chk("R6 held while stopped", delivered == expected_total - DEPTH,
        delivered, expected_total - DEPTH);
    drain_check("R6 overflow drop");
    send_pkt(PKT, 1, 0, 0, 0);
    drain_check("R6 recovery");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule